// File: doc/BRIEF.md
# Fifth-Order Sinc Decimator (64x)

This block turns the one-bit stream of a delta-sigma modulator into signed 24-bit output words. It divides its system clock by six to make a modulator-rate sample enable, which it also drives out so that the modulator (or the bitstream source that stands in for it) can advance in step. On every enabled cycle the incoming bit counts as +1 or −1 and feeds a cascade of five running sums. Once every 64 samples the last sum is captured. Five difference stages then turn it into one filtered value, and that value is scaled and clamped to 24 bits.

The overall response is the fifth power of a 64-tap moving average. It therefore has nulls at the output word rate and at every whole multiple of it. A one-cycle strobe marks each new word. A settled flag tells the consumer when the output no longer depends on the zeros held in the filter at reset. A synchronous reset clears every sum, every difference stage and the decimation phase, so several instances released by the same reset edge produce their words on the same cycle.

Top module: `sinc5_decim`

## Requirements
- R1: `sample_en` is high for exactly one system clock out of every 6, at a fixed spacing of 6 clocks.
- R2: `out_strobe` is a single-cycle pulse. Consecutive pulses are exactly 384 system clocks apart, with exactly 64 `sample_en` pulses between them.
- R3: A bit of 1 counts as +1 and a bit of 0 counts as −1. An all-zero stream gives the word 0x800000 (negative full scale).
- R4: For an input repeating with period p samples (p a power of two dividing 64) that holds k ones per period, each settled word equals 2^23·(2k−p)/p as 24-bit two's complement, clamped to the 24-bit range.
- R5: A value of +2^23 or more is clamped to 0x7FFFFF, so an all-ones stream gives 0x7FFFFF.
- R6: An input at a null of the response (alternating 0/1, which is 32 times the word rate) gives the word 0x000000.
- R7: `settled` is low for the first four strobes after reset, rises in the same cycle as the fifth strobe, and stays high until the next reset. The fifth word after reset already has its exact settled value.
- R8: While `rst` is high, `dout` reads 0 and `out_strobe` and `settled` read low. After reset the first strobe arrives at the same fixed latency from the reset release, regardless of the state before reset.
- R9: `dout` changes only in the cycle in which `out_strobe` is high and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; restarts sums, differences and decimation phase |
| mod_bit | input | 1 | Modulator output bit, taken on cycles where `sample_en` is high |
| sample_en | output | 1 | Modulator-rate enable, one clock in six |
| dout | output | 24 | Latest filtered word, two's complement |
| out_strobe | output | 1 | One-cycle pulse marking a new `dout` |
| settled | output | 1 | High from the fifth word after reset onward |

## Verification
The assertions take for granted that `rst` is high from time zero for at least one clock edge. They also assume that `mod_bit` carries meaning only on the clock edge that ends a `sample_en` cycle, so the running sums change on no other edge. The stimulus applies reset before every case. It changes `mod_bit` only at falling edges, and only right after it sees `sample_en` high, so each pattern bit is taken exactly once. Between cases it waits a random number of clocks first, which places each reset at an arbitrary point inside a conversion.

// File: rtl/sinc5_pkg.sv
package sinc5_pkg;

   localparam int unsigned DEF_DIV   = 6;
   localparam int unsigned DEF_OSR   = 64;
   localparam int unsigned DEF_ORDER = 5;
   localparam int unsigned DEF_OUT_W = 24;

   // Wrap-around width: growth of ORDER stages of OSR plus sign and one
   // extra bit so that the exact full-scale value +OSR^ORDER is representable.
   function automatic int unsigned acc_width(input int unsigned order,
                                             input int unsigned osr);
      return order * $clog2(osr) + 2;
   endfunction

endpackage

// File: rtl/sinc_rate_gen.sv
module sinc_rate_gen #(
   parameter int unsigned DIV = 6
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= (cnt == LAST);
         cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   // checker counter: clocks since the previous tick
   int  gap;
   logic seen;
   always_ff @(posedge clk) begin
      if (rst) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (tick_o) begin
         gap  <= 1;
         seen <= 1'b1;
      end else begin
         gap  <= gap + 1;
      end
   end

   a_r1_tick_period : assert property (@(posedge clk) disable iff (rst)
      (tick_o && seen) |-> (gap == int'(DIV)));

   a_r1_tick_single : assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o);

endmodule

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
   parameter int unsigned ORDER = 5,
   parameter int unsigned ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    tick_i,
   input  logic                    bit_i,
   output logic signed [ACC_W-1:0] sum_o
);
   logic signed [ACC_W-1:0] acc [ORDER];
   logic signed [ACC_W-1:0] step;

   assign step = bit_i ? ACC_W'(1) : {ACC_W{1'b1}};

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < ORDER; k++) acc[k] <= '0;
      end else if (tick_i) begin
         acc[0] <= acc[0] + step;
         for (int k = 1; k < ORDER; k++) acc[k] <= acc[k] + acc[k-1];
      end
   end

   assign sum_o = acc[ORDER-1];

   // R3: sums only move on modulator-rate cycles
   a_r3_integ_idle : assert property (@(posedge clk) disable iff (rst)
      !tick_i |=> $stable(sum_o));

endmodule

// File: rtl/sinc_comb_seq.sv
module sinc_comb_seq #(
   parameter int unsigned ORDER = 5,
   parameter int unsigned OSR   = 64,
   parameter int unsigned ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    tick_i,
   input  logic signed [ACC_W-1:0] sum_i,
   output logic signed [ACC_W-1:0] res_o,
   output logic                    res_vld_o
);
   localparam int unsigned LW = $clog2(OSR);
   localparam int unsigned IW = $clog2(ORDER);
   localparam logic [LW-1:0] CNT_LAST = LW'(OSR - 1);
   localparam logic [IW-1:0] IDX_LAST = IW'(ORDER - 1);

   logic [LW-1:0]           phase;
   logic                    cap_pend;
   logic                    busy;
   logic [IW-1:0]           idx;
   logic signed [ACC_W-1:0] val;
   logic signed [ACC_W-1:0] prev [ORDER];

   always_ff @(posedge clk) begin
      if (rst) begin
         phase     <= '0;
         cap_pend  <= 1'b0;
         busy      <= 1'b0;
         idx       <= '0;
         val       <= '0;
         res_vld_o <= 1'b0;
         for (int k = 0; k < ORDER; k++) prev[k] <= '0;
      end else begin
         res_vld_o <= 1'b0;
         cap_pend  <= 1'b0;
         if (tick_i) begin
            phase <= phase + 1'b1;
            if (phase == CNT_LAST) cap_pend <= 1'b1;
         end
         if (cap_pend) begin
            val  <= sum_i;
            busy <= 1'b1;
            idx  <= '0;
         end else if (busy) begin
            val       <= val - prev[idx];
            prev[idx] <= val;
            if (idx == IDX_LAST) begin
               busy      <= 1'b0;
               res_vld_o <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assign res_o = val;

   // R2: a new capture never lands while the difference pass is running
   a_r2_cap_idle : assert property (@(posedge clk) disable iff (rst)
      cap_pend |-> !busy);

   a_r2_result_pulse : assert property (@(posedge clk) disable iff (rst)
      res_vld_o |=> !res_vld_o);

endmodule

// File: rtl/sinc_out_stage.sv
module sinc_out_stage #(
   parameter int unsigned ORDER = 5,
   parameter int unsigned ACC_W = 32,
   parameter int unsigned OUT_W = 24,
   parameter int unsigned SHIFT = 7
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [ACC_W-1:0] res_i,
   input  logic                    res_vld_i,
   output logic [OUT_W-1:0]        dout_o,
   output logic                    strobe_o,
   output logic                    settled_o
);
   localparam int unsigned SCW = $clog2(ORDER);
   localparam logic [SCW-1:0] SC_LAST = SCW'(ORDER - 1);
   localparam logic signed [ACC_W-1:0] POS_MAX = ACC_W'((64'd1 << (OUT_W - 1)) - 64'd1);
   localparam logic signed [ACC_W-1:0] NEG_MIN = ~POS_MAX;

   logic signed [ACC_W-1:0] scaled;
   logic [OUT_W-1:0]        clamped;
   logic [SCW-1:0]          scnt;

   if (SHIFT == 0) begin : g_noshift
      assign scaled = res_i;
   end else begin : g_shift
      assign scaled = res_i >>> SHIFT;
   end

   always_comb begin
      if (scaled > POS_MAX)      clamped = POS_MAX[OUT_W-1:0];
      else if (scaled < NEG_MIN) clamped = NEG_MIN[OUT_W-1:0];
      else                       clamped = scaled[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_o    <= '0;
         strobe_o  <= 1'b0;
         settled_o <= 1'b0;
         scnt      <= '0;
      end else begin
         strobe_o <= res_vld_i;
         if (res_vld_i) begin
            dout_o <= clamped;
            if (scnt == SC_LAST) settled_o <= 1'b1;
            else                 scnt      <= scnt + 1'b1;
         end
      end
   end

   a_r2_strobe_pulse : assert property (@(posedge clk) disable iff (rst)
      strobe_o |=> !strobe_o);

   a_r7_settled_hold : assert property (@(posedge clk) disable iff (rst)
      settled_o |=> settled_o);

   a_r7_rise_on_strobe : assert property (@(posedge clk) disable iff (rst)
      $rose(settled_o) |-> strobe_o);

   a_r9_dout_hold : assert property (@(posedge clk) disable iff (rst)
      !res_vld_i |=> $stable(dout_o));

endmodule

// File: rtl/sinc5_decim.sv
module sinc5_decim
   import sinc5_pkg::*;
#(
   parameter int unsigned DIV   = DEF_DIV,
   parameter int unsigned OSR   = DEF_OSR,
   parameter int unsigned ORDER = DEF_ORDER,
   parameter int unsigned OUT_W = DEF_OUT_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mod_bit,
   output logic             sample_en,
   output logic [OUT_W-1:0] dout,
   output logic             out_strobe,
   output logic             settled
);
   localparam int unsigned LOG2OSR = $clog2(OSR);
   localparam int unsigned ACC_W   = acc_width(ORDER, OSR);
   localparam int unsigned SHIFT   = ORDER * LOG2OSR - (OUT_W - 1);

   if (OSR != (1 << LOG2OSR) || OSR < 2) begin : g_bad_osr
      $error("OSR must be a power of two of at least 2");
   end
   if (ORDER < 2) begin : g_bad_order
      $error("ORDER must be at least 2");
   end
   if (DIV < 2) begin : g_bad_div
      $error("DIV must be at least 2");
   end
   if (ORDER * LOG2OSR < OUT_W - 1) begin : g_bad_width
      $error("OUT_W exceeds filter growth");
   end
   if (DIV * OSR <= ORDER + 2) begin : g_bad_rate
      $error("difference pass does not fit in one word period");
   end

   logic                    tick;
   logic signed [ACC_W-1:0] sum;
   logic signed [ACC_W-1:0] res;
   logic                    res_vld;

   sinc_rate_gen #(.DIV(DIV)) u_rate (
      .clk    (clk),
      .rst    (rst),
      .tick_o (tick)
   );

   sinc_integ_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick),
      .bit_i  (mod_bit),
      .sum_o  (sum)
   );

   sinc_comb_seq #(.ORDER(ORDER), .OSR(OSR), .ACC_W(ACC_W)) u_comb (
      .clk       (clk),
      .rst       (rst),
      .tick_i    (tick),
      .sum_i     (sum),
      .res_o     (res),
      .res_vld_o (res_vld)
   );

   sinc_out_stage #(.ORDER(ORDER), .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_out (
      .clk       (clk),
      .rst       (rst),
      .res_i     (res),
      .res_vld_i (res_vld),
      .dout_o    (dout),
      .strobe_o  (out_strobe),
      .settled_o (settled)
   );

   assign sample_en = tick;

   // R2: words never appear on a modulator-rate cycle
   a_r2_strobe_off_tick : assert property (@(posedge clk) disable iff (rst)
      out_strobe |-> !sample_en);

endmodule

// File: tb/sim_sinc5_decim.sv
`timescale 1ns/1ps
module sim_sinc5_decim;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mod_bit = 1'b0;
   logic        sample_en;
   logic [23:0] dout;
   logic        out_strobe;
   logic        settled;

   int checks = 0;
   int fails  = 0;
   int first_lat = -1;

   always #2 clk = ~clk;

   sinc5_decim u0 (
      .clk        (clk),
      .rst        (rst),
      .mod_bit    (mod_bit),
      .sample_en  (sample_en),
      .dout       (dout),
      .out_strobe (out_strobe),
      .settled    (settled)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_word(input logic [63:0] pat, input int plen);
      longint k = 0;
      longint v;
      for (int i = 0; i < plen; i++) k += longint'(pat[i]);
      v = ((longint'(1) << 23) * (2 * k - plen)) / plen;
      if (v > 8388607)  v = 8388607;
      if (v < -8388608) v = -8388608;
      return 24'(v);
   endfunction

   task automatic run_case(input logic [63:0] pat, input int plen,
                           input int pre_idle, input string tag);
      int cyc = 0, pidx = 0, words = 0, last_se = -1, last_st = -1;
      int nse = 0, hold_bad = 0, se_bad = 0;
      logic [23:0] held;
      logic [23:0] want;
      want = exp_word(pat, plen);
      repeat (pre_idle) @(negedge clk);
      rst = 1'b1;
      mod_bit = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 dout in reset", dout, 0);
      chk("R8 strobe in reset", out_strobe, 0);
      chk("R8 settled in reset", settled, 0);
      rst = 1'b0;
      held = dout;
      while (words < 7) begin
         @(negedge clk);
         cyc++;
         if (out_strobe) begin
            words++;
            if (words == 1) begin
               if (first_lat < 0) first_lat = cyc;
               chk("R8 first strobe latency", cyc, first_lat);
            end else begin
               chk("R2 strobe spacing", cyc - last_st, 384);
               chk("R2 samples per word", nse, 64);
            end
            if (words <= 5) chk("R7 settled flag", settled, (words == 5) ? 1 : 0);
            if (words >= 5) chk(tag, dout, want);
            last_st = cyc;
            nse = 0;
            held = dout;
         end else if (dout != held) begin
            hold_bad++;
         end
         if (sample_en) begin
            if (last_se >= 0 && cyc - last_se != 6) se_bad++;
            last_se = cyc;
            mod_bit = pat[pidx];
            pidx = (pidx + 1) % plen;
            nse++;
         end
      end
      chk("R9 dout held between strobes", hold_bad, 0);
      chk("R1 sample_en spacing", se_bad, 0);
      chk("R7 settled stays high", settled, 1);
   endtask

   initial begin
      logic [63:0] rp;
      void'($urandom(32'd5141));
      run_case(64'h1, 1, 0, "R5 all ones clamps to 0x7FFFFF");
      run_case(64'h0, 1, 17, "R3 all zeros gives 0x800000");
      run_case(64'h2, 2, 200, "R6 alternating input nulls to zero");
      run_case(64'hE, 4, 5, "R4 three of four ones");
      run_case(64'h10, 8, 91, "R4 one of eight ones");
      run_case(64'h1, 2, 3, "R6 alternating phase swapped");
      for (int n = 0; n < 6; n++) begin
         rp = {$urandom(), $urandom()};
         run_case(rp, (n % 2 == 0) ? 64 : 32, int'($urandom_range(0, 383)),
                  "R4 random periodic pattern");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 4);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule